// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and date entirely in packed BCD: seconds, minutes, hours (24-hour), day of week, day of month, month, a two-digit year and a separate century byte. Each byte holds the tens digit in bits 7:4 and the units digit in bits 3:0. A one-cycle `sec_tick` pulse, produced elsewhere once per second, advances the count. Carries ripple from seconds up to the century. Day-of-month length follows the month and a leap-year rule that takes the century byte into account.

Every field is exposed as its own byte output, so a register file can map the fields directly. A host can load any single field through a simple write port. A `time_valid` status bit falls for the cycle in which the fields are being rewritten. A reader that sees it high knows the bytes form a consistent snapshot.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day of week 01, day of month 01, month 01, year 00, century 20 (the `CENTURY_INIT` default), and `time_valid` is 1.
- R2: A `sec_tick` sampled high at clock edge k makes the seconds field step by one BCD count at edge k+1. With no tick and no write, all fields hold their values.
- R3: Seconds and minutes count 00 to 59. On wrap to 00 they pass a carry to the next field.
- R4: Hours count 00 to 23. The wrap from 23 to 00 advances both day of week and day of month.
- R5: Day of week counts 01 to 07 and wraps from 07 back to 01.
- R6: Day of month wraps to 01 after its last day. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. For month 02 it is 29 in a leap year and 28 otherwise. A year is a leap year when year mod 4 is 0 and year is not 00, or when year is 00 and century mod 4 is 0.
- R7: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00 and advances the century, which wraps from 99 to 00.
- R8: `time_valid` is 0 in the cycle after a sampled `sec_tick`, which is the cycle whose closing edge rewrites the fields. It is 1 in every other cycle.
- R9: With `wr_en` high at an edge, `wr_data` is loaded at that edge into the field selected by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century. A write does not change `time_valid`.
- R10: When a write and an advance meet at the same edge, the written field takes `wr_data`. The other fields still advance, with carries computed from the values held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Host field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD value to load |
| out_sec | output | 8 | Seconds, BCD |
| out_min | output | 8 | Minutes, BCD |
| out_hour | output | 8 | Hours 00-23, BCD |
| out_dow | output | 8 | Day of week 01-07, BCD |
| out_dom | output | 8 | Day of month, BCD |
| out_mon | output | 8 | Month 01-12, BCD |
| out_year | output | 8 | Year within century, BCD |
| out_cent | output | 8 | Century, BCD |
| time_valid | output | 1 | High when fields are not being rewritten |

## Verification
The hardest situations to reach are the long carry chains: a February end of month in a century year, and the year 99 rollover into the century. A free-running tick would need years of simulated time to get there. The bench therefore loads every field through the write port to one second before each such boundary, ticks once, and checks the result. These cases include 2000 against 2100, 2023 against 2024, and century 99 wrapping to 00. Random ticks mixed with legal random field writes then cover carries, and collisions between writes and advances, against a binary reference model.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 8;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  typedef logic [FIELD_W-1:0] bcd_t;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  // One BCD count up; caller handles wrap.
  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd_t field_floor(int idx);
    if (idx == F_DOW || idx == F_DOM || idx == F_MON) return 8'h01;
    return 8'h00;
  endfunction

  function automatic bcd_t field_ceiling(int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DOW:        return 8'h07;
      F_DOM:        return 8'h31;
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  // Divisible by 4 in BCD: even tens -> units 0/4/8, odd tens -> units 2/6.
  function automatic logic bcd_div4(bcd_t v);
    return v[1:0] == {v[4], 1'b0};
  endfunction

  function automatic logic leap_year(bcd_t yr, bcd_t cen);
    if (yr == 8'h00) return bcd_div4(cen);
    return bcd_div4(yr);
  endfunction

  function automatic bcd_t month_last_day(bcd_t mon, logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Which field feeds the carry into field idx.
  function automatic int carry_source(int idx);
    if (idx == F_DOW || idx == F_DOM) return F_HOUR;
    if (idx == F_MON) return F_DOM;
    return idx - 1;
  endfunction
endpackage

// File: rtl/bcd_field_step.sv
module bcd_field_step
  import bcd_cal_pkg::*;
#(
  parameter bcd_t FLOOR = 8'h00
) (
  input  logic [FIELD_W-1:0] cur,
  input  logic [FIELD_W-1:0] ceiling,
  input  logic               step_in,
  output logic [FIELD_W-1:0] nxt,
  output logic               carry_out
);
  logic at_top;

  assign at_top    = (cur == ceiling);
  assign carry_out = step_in & at_top;

  always_comb begin
    if (!step_in)    nxt = cur;
    else if (at_top) nxt = FLOOR;
    else             nxt = bcd_inc(cur);
  end
endmodule

// File: rtl/bcd_month_len.sv
module bcd_month_len
  import bcd_cal_pkg::*;
(
  input  logic [FIELD_W-1:0] month,
  input  logic [FIELD_W-1:0] year,
  input  logic [FIELD_W-1:0] century,
  output logic [FIELD_W-1:0] last_day
);
  logic leap;

  assign leap     = leap_year(year, century);
  assign last_day = month_last_day(month, leap);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] CENTURY_INIT = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] out_sec,
  output logic [FIELD_W-1:0] out_min,
  output logic [FIELD_W-1:0] out_hour,
  output logic [FIELD_W-1:0] out_dow,
  output logic [FIELD_W-1:0] out_dom,
  output logic [FIELD_W-1:0] out_mon,
  output logic [FIELD_W-1:0] out_year,
  output logic [FIELD_W-1:0] out_cent,
  output logic               time_valid
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_d;
  logic [NUM_FIELDS-1:0]              step_in;
  logic [NUM_FIELDS-1:0]              carry_out;
  logic [FIELD_W-1:0]                 dom_last;
  logic                               update_busy;

  // Named events for the checker.
  logic advance, day_roll, week_roll, year_roll, cent_roll;
  assign advance   = update_busy;
  assign day_roll  = carry_out[F_HOUR];
  assign week_roll = carry_out[F_DOW];
  assign year_roll = carry_out[F_YEAR];
  assign cent_roll = carry_out[F_CENT];

  bcd_month_len u_mlen (
    .month   (fld_q[F_MON]),
    .year    (fld_q[F_YEAR]),
    .century (fld_q[F_CENT]),
    .last_day(dom_last)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [FIELD_W-1:0] ceil_i;
    if (i == 0) begin : g_head
      assign step_in[i] = advance;
    end else begin : g_chain
      assign step_in[i] = carry_out[carry_source(i)];
    end
    if (i == F_DOM) begin : g_dyn
      assign ceil_i = dom_last;
    end else begin : g_fix
      assign ceil_i = field_ceiling(i);
    end
    bcd_field_step #(.FLOOR(field_floor(i))) u_step (
      .cur      (fld_q[i]),
      .ceiling  (ceil_i),
      .step_in  (step_in[i]),
      .nxt      (fld_d[i]),
      .carry_out(carry_out[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      update_busy <= 1'b0;
      for (int i = 0; i < NUM_FIELDS; i++)
        fld_q[i] <= (i == F_CENT) ? CENTURY_INIT : field_floor(i);
    end else begin
      update_busy <= sec_tick;
      for (int i = 0; i < NUM_FIELDS; i++)
        fld_q[i] <= (wr_en && wr_sel == SEL_W'(i)) ? wr_data : fld_d[i];
    end
  end

  assign out_sec    = fld_q[F_SEC];
  assign out_min    = fld_q[F_MIN];
  assign out_hour   = fld_q[F_HOUR];
  assign out_dow    = fld_q[F_DOW];
  assign out_dom    = fld_q[F_DOM];
  assign out_mon    = fld_q[F_MON];
  assign out_year   = fld_q[F_YEAR];
  assign out_cent   = fld_q[F_CENT];
  assign time_valid = ~update_busy;
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] out_sec,
  input logic [7:0] out_min,
  input logic [7:0] out_hour,
  input logic [7:0] out_dow,
  input logic [7:0] out_year,
  input logic [7:0] out_cent,
  input logic       time_valid,
  input logic       advance,
  input logic       day_roll,
  input logic       week_roll,
  input logic       year_roll,
  input logic       cent_roll
);
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !time_valid); // R8
  AST_VALID_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> time_valid); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (time_valid && !wr_en) |=> ($stable(out_sec) && $stable(out_min) && $stable(out_hour))); // R2
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_en && out_sec == 8'h59) |=> out_sec == 8'h00); // R3
  AST_DAY_ROLL_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |-> (out_hour == 8'h23 && out_min == 8'h59 && out_sec == 8'h59)); // R4
  AST_WEEK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (week_roll && !wr_en) |=> out_dow == 8'h01); // R5
  AST_CENT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (year_roll && !wr_en) |=> (out_year == 8'h00 && out_cent != $past(out_cent))); // R7
  AST_CENT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cent_roll && !wr_en) |=> out_cent == 8'h00); // R7
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd6) |=> out_year == $past(wr_data)); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> out_sec == $past(wr_data)); // R10
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sec_tick  (sec_tick),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .out_sec   (out_sec),
  .out_min   (out_min),
  .out_hour  (out_hour),
  .out_dow   (out_dow),
  .out_year  (out_year),
  .out_cent  (out_cent),
  .time_valid(time_valid),
  .advance   (advance),
  .day_roll  (day_roll),
  .week_roll (week_roll),
  .year_roll (year_roll),
  .cent_roll (cent_roll)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] out_sec, out_min, out_hour, out_dow, out_dom, out_mon, out_year, out_cent;
  logic       time_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state in binary: sec,min,hour,dow,dom,mon,year,cent
  int m [8];
  bit busy_m = 1'b0;

  always #2 clk = ~clk;

  bcd_calendar uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .out_sec(out_sec), .out_min(out_min), .out_hour(out_hour), .out_dow(out_dow),
    .out_dom(out_dom), .out_mon(out_mon), .out_year(out_year), .out_cent(out_cent),
    .time_valid(time_valid)
  );

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(int mo, int full_year);
    bit leap;
    leap = (full_year % 4 == 0) && ((full_year % 100 != 0) || (full_year % 400 == 0));
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] dut_field(int i);
    case (i)
      0: return out_sec;   1: return out_min;  2: return out_hour; 3: return out_dow;
      4: return out_dom;   5: return out_mon;  6: return out_year; default: return out_cent;
    endcase
  endfunction

  task automatic model_advance();
    int dim;
    dim = days_in(m[5], m[7] * 100 + m[6]);
    m[0]++;
    if (m[0] < 60) return;
    m[0] = 0; m[1]++;
    if (m[1] < 60) return;
    m[1] = 0; m[2]++;
    if (m[2] < 24) return;
    m[2] = 0;
    m[3] = (m[3] == 7) ? 1 : m[3] + 1;
    if (m[4] != dim) begin m[4]++; return; end
    m[4] = 1; m[5]++;
    if (m[5] <= 12) return;
    m[5] = 1; m[6]++;
    if (m[6] < 100) return;
    m[6] = 0;
    m[7] = (m[7] == 99) ? 0 : m[7] + 1;
  endtask

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < 8; i++) check(tag, $sformatf("field%0d", i), dut_field(i), to_bcd(m[i]));
    check(tag, "time_valid", {7'd0, time_valid}, {7'd0, ~busy_m});
  endtask

  task automatic cyc(bit tk, bit we, logic [2:0] sel, logic [7:0] dat, string tag);
    sec_tick = tk; wr_en = we; wr_sel = sel; wr_data = dat;
    @(posedge clk);
    if (busy_m) model_advance();
    if (we) m[sel] = from_bcd(dat);
    busy_m = tk;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic set_all(int s, int mi, int h, int dw, int d, int mo, int y, int c);
    int v [8];
    v[0] = s; v[1] = mi; v[2] = h; v[3] = dw; v[4] = d; v[5] = mo; v[6] = y; v[7] = c;
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 3'(i), to_bcd(v[i]), "R9");
  endtask

  task automatic tick_settle(string tag);
    cyc(1'b1, 1'b0, 3'd0, 8'h00, tag);
    cyc(1'b0, 1'b0, 3'd0, 8'h00, tag);
  endtask

  function automatic logic [7:0] legal_value(int sel, int r);
    case (sel)
      0, 1: return to_bcd(r % 60);
      2:    return to_bcd(r % 24);
      3:    return to_bcd(1 + r % 7);
      4:    return to_bcd(1 + r % 28);
      5:    return to_bcd(1 + r % 12);
      default: return to_bcd(r % 100);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 1; m[4] = 1; m[5] = 1; m[6] = 0; m[7] = 20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R2/R8: single tick, valid low one cycle, seconds step
    cyc(1'b1, 1'b0, 3'd0, 8'h00, "R2");
    check("R8", "valid after tick", {7'd0, time_valid}, 8'h00);
    cyc(1'b0, 1'b0, 3'd0, 8'h00, "R2");
    check("R2", "sec literal", out_sec, 8'h01);
    check("R8", "valid restored", {7'd0, time_valid}, 8'h01);
    cyc(1'b0, 1'b0, 3'd0, 8'h00, "R2");

    // R3: minute carry
    set_all(59, 58, 10, 2, 10, 6, 30, 20);
    tick_settle("R3");
    check("R3", "min carry", out_min, 8'h59);
    check("R3", "sec wrap", out_sec, 8'h00);

    // R4/R5/R7: new year 1999 -> 2000, week wrap
    set_all(59, 59, 23, 7, 31, 12, 99, 19);
    tick_settle("R7");
    check("R4", "hour wrap", out_hour, 8'h00);
    check("R5", "dow wrap", out_dow, 8'h01);
    check("R7", "month wrap", out_mon, 8'h01);
    check("R7", "year wrap", out_year, 8'h00);
    check("R7", "century carry", out_cent, 8'h20);

    // R6: February in century and normal years
    set_all(59, 59, 23, 3, 28, 2, 0, 20);
    tick_settle("R6");
    check("R6", "2000 leap", out_dom, 8'h29);
    set_all(59, 59, 23, 3, 29, 2, 0, 20);
    tick_settle("R6");
    check("R6", "feb29 end", out_mon, 8'h03);
    set_all(59, 59, 23, 3, 28, 2, 0, 21);
    tick_settle("R6");
    check("R6", "2100 not leap", out_dom, 8'h01);
    set_all(59, 59, 23, 3, 28, 2, 24, 20);
    tick_settle("R6");
    check("R6", "2024 leap", out_dom, 8'h29);
    set_all(59, 59, 23, 3, 28, 2, 23, 20);
    tick_settle("R6");
    check("R6", "2023 not leap", out_mon, 8'h03);
    set_all(59, 59, 23, 3, 30, 4, 23, 20);
    tick_settle("R6");
    check("R6", "april end", out_mon, 8'h05);
    set_all(59, 59, 23, 3, 30, 1, 23, 20);
    tick_settle("R6");
    check("R6", "jan 30 to 31", out_dom, 8'h31);

    // R7: century 99 -> 00
    set_all(59, 59, 23, 5, 31, 12, 99, 99);
    tick_settle("R7");
    check("R7", "century wrap", out_cent, 8'h00);

    // R10: write collides with advance
    set_all(59, 10, 5, 2, 5, 5, 5, 20);
    cyc(1'b1, 1'b0, 3'd0, 8'h00, "R10");
    cyc(1'b0, 1'b1, 3'd0, 8'h42, "R10");
    check("R10", "write wins", out_sec, 8'h42);
    check("R10", "carry still", out_min, 8'h11);
    check("R9", "write keeps valid", {7'd0, time_valid}, 8'h01);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int r, sel;
      bit tk, we;
      r   = int'($urandom % 1000);
      tk  = ($urandom % 2) == 0;
      we  = ($urandom % 10) == 0;
      sel = int'($urandom % 8);
      cyc(tk, we, 3'(sel), legal_value(sel, r), "R2");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule